// File: doc/BRIEF.md
# Five-Level Stacked-Carrier Leg Modulator

This block produces the eight gate enables for one phase leg of a five-level diode-clamped inverter. A signed, sampled reference word is compared with four triangular carriers. The carriers are stacked one above the other and together span the reference range. The number of carriers that the reference rises above selects one of five output levels. Each level maps to a fixed eight-switch leg pattern.

All four carriers come from one shared up/down counter, so they have the same frequency, amplitude and phase. The `band_i` setting is both the height of one carrier band and the half-period of the triangle, in clock cycles. The reference is sampled once per carrier period, at the peak, so a reference update cannot disturb a half-period that has already started. Dead-time insertion, reference generation and the power stage are outside this block.

Top module: `pwm5_leg_mod`

## Requirements
- R1: With band height B = `band_i`, the shared counter starts at 0 after reset. It climbs by one per cycle to B, falls by one per cycle to 0, and repeats with a period of 2·B cycles. Carrier k (k = 0..3) equals counter + k·B − 2·B, so the set spans −2·B to +2·B and zero lies in the middle.
- R2: `level_o` is the number of carriers that are strictly below the held reference. It is evaluated against the counter value of the previous cycle and registered, so it is one cycle late.
- R3: A held reference that equals a carrier value does not count as exceeding that carrier.
- R4: A held reference above +2·B gives level 4 in every cycle. A held reference at or below −2·B gives level 0 in every cycle.
- R5: `gate_o` equals 8'h0F shifted left by `level_o`. Bit 7 is S1, down to bit 4 for S4; bit 3 is S1', down to bit 0 for S4'. So 11110000 is the top level and 00001111 is the bottom level, and exactly four bits are set.
- R6: Each complementary enable is the inverse of its partner: `gate_o[3:0]` equals the bitwise inverse of `gate_o[7:4]`.
- R7: While `rst` is high, and on the cycle after it is released, `level_o` is 2 and `gate_o` is 8'b00111100.
- R8: `ref_i` is captured only on a clock edge at which the counter equals B. Between captures the held reference does not change, whatever `ref_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| band_i | input | CNT_W | Carrier band height and triangle half-period in cycles |
| ref_i | input | REF_W | Signed sampled reference |
| gate_o | output | 8 | {S1..S4, S1'..S4'} switch enables |
| level_o | output | 3 | Output level index, 0 (bottom) to 4 (top) |

## Verification
The assertions assume that `band_i` is at least 1 and changes only while `rst` is high. Under that assumption the counter never exceeds the band, and the saturation bounds of ±2·B hold. The stimulus changes the band only inside a reset. It drives references that saturate, references that fall exactly on carrier peaks and troughs, and references that change in the middle of a half-period.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

    localparam int NUM_CAR = 4;
    localparam int LVL_W   = 3;

    typedef logic signed [31:0] wide_t;

    typedef enum logic [LVL_W-1:0] {
        LV_NEG2 = 3'd0,
        LV_NEG1 = 3'd1,
        LV_ZERO = 3'd2,
        LV_POS1 = 3'd3,
        LV_POS2 = 3'd4
    } level_e;

    typedef struct packed {
        logic [NUM_CAR-1:0] upper;   // S1..S4, S1 in MSB
        logic [NUM_CAR-1:0] lower;   // S1'..S4'
    } gate_t;

    // Carrier k sits k bands above the bottom carrier, which starts at -2*band.
    function automatic wide_t carrier_of(input int k, input wide_t cnt, input wide_t band);
        return cnt + wide_t'(k) * band - 2 * band;
    endfunction

    // A window of four ones slides right one place per level step down.
    function automatic gate_t pattern_of(input level_e lvl);
        logic [2*NUM_CAR-1:0] p;
        p = 8'h0F << lvl;
        return gate_t'(p);
    endfunction

    function automatic level_e count_above(input logic [NUM_CAR-1:0] above);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int i = 0; i < NUM_CAR; i++) n = n + LVL_W'(above[i]);
        return level_e'(n);
    endfunction

endpackage

// File: rtl/pwm5_tri_counter.sv
module pwm5_tri_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] band_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic             peak_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             up_q;
    logic [CNT_W:0]   cnt_nxt_ext;

    assign cnt_nxt_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_nxt_ext >= {1'b0, band_i}) up_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign up_o   = up_q;
    assign peak_o = (cnt_q == band_i);

    AST_CNT_RISE: assert property (@(posedge clk) disable iff (rst)
        up_q |=> cnt_q == $past(cnt_q) + 1'b1);                  // R1
    AST_CNT_FALL: assert property (@(posedge clk) disable iff (rst)
        !up_q |=> cnt_q == $past(cnt_q) - 1'b1);                 // R1

endmodule

// File: rtl/pwm5_cmp_bank.sv
module pwm5_cmp_bank
    import pwm5_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [CNT_W-1:0]        band_i,
    input  logic                    peak_i,
    input  logic signed [REF_W-1:0] ref_i,
    output level_e                  level_o
);
    logic signed [REF_W-1:0] ref_q;
    level_e                  level_q;
    logic [NUM_CAR-1:0]      above;
    wide_t                   ref_w, cnt_w, band_w;

    assign ref_w  = wide_t'(ref_q);
    assign cnt_w  = wide_t'(cnt_i);
    assign band_w = wide_t'(band_i);

    for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
        wide_t car_w;
        assign car_w    = carrier_of(k, cnt_w, band_w);
        assign above[k] = (ref_w > car_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            level_q <= LV_ZERO;
        end else begin
            if (peak_i) ref_q <= ref_i;
            level_q <= count_above(above);
        end
    end

    assign level_o = level_q;

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !peak_i |=> $stable(ref_q));                              // R8
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (ref_w > 2 * band_w) |=> level_q == LV_POS2);            // R4
    AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
        (ref_w <= -2 * band_w) |=> level_q == LV_NEG2);          // R4

endmodule

// File: rtl/pwm5_leg_decode.sv
module pwm5_leg_decode
    import pwm5_pkg::*;
(
    input  level_e level_i,
    output gate_t  gate_o
);
    assign gate_o = pattern_of(level_i);
endmodule

// File: rtl/pwm5_leg_mod.sv
module pwm5_leg_mod
    import pwm5_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        band_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [7:0]              gate_o,
    output logic [2:0]              level_o
);
    logic [CNT_W-1:0] cnt;
    logic             up;
    logic             peak;
    level_e           level;
    gate_t            gate;

    pwm5_tri_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .band_i(band_i),
        .cnt_o(cnt), .up_o(up), .peak_o(peak)
    );

    pwm5_cmp_bank #(.CNT_W(CNT_W), .REF_W(REF_W)) u_cmp (
        .clk(clk), .rst(rst), .cnt_i(cnt), .band_i(band_i),
        .peak_i(peak), .ref_i(ref_i), .level_o(level)
    );

    pwm5_leg_decode u_dec (.level_i(level), .gate_o(gate));

    assign gate_o  = gate;
    assign level_o = level;

    AST_RESET_MID: assert property (@(posedge clk)
        $past(rst) |-> (level_o == 3'd2 && gate_o == 8'h3C));    // R7
    AST_FOUR_ON: assert property (@(posedge clk) disable iff (rst)
        $countones(gate_o) == 4);                                 // R5

endmodule

// File: tb/tb_pwm5_leg_mod.sv
module tb_pwm5_leg_mod;
    localparam int CNT_W = 8;
    localparam int REF_W = 12;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [CNT_W-1:0]        band_i = 8'd20;
    logic signed [REF_W-1:0] ref_i = '0;
    logic [7:0]              gate_o;
    logic [2:0]              level_o;

    int    n_run = 0, n_fail = 0, cyc = 0;
    bit    done = 1'b0;
    string tag = "R7";
    int    exp_q[$];

    // bench model state
    int m_cnt = 0, m_ref = 0, m_lvl = 2;
    bit m_up = 1'b1;

    pwm5_leg_mod #(.CNT_W(CNT_W), .REF_W(REF_W)) dut (
        .clk(clk), .rst(rst), .band_i(band_i), .ref_i(ref_i),
        .gate_o(gate_o), .level_o(level_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input string rq, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // Expected-value producer: follows the requirement rules at each edge.
    always @(posedge clk) begin
        int b, nl;
        b = int'(band_i);
        if (rst) begin
            m_cnt = 0; m_up = 1'b1; m_ref = 0; m_lvl = 2;
        end else begin
            nl = 0;
            for (int k = 0; k < 4; k++)
                if (m_ref > m_cnt + k * b - 2 * b) nl++;
            if (m_cnt == b) m_ref = int'(ref_i);
            if (m_up) begin
                if (m_cnt + 1 >= b) m_up = 1'b0;
                m_cnt++;
            end else begin
                if (m_cnt == 1) m_up = 1'b1;
                m_cnt--;
            end
            m_lvl = nl;
        end
        exp_q.push_back(m_lvl);
    end

    // Monitor: compares DUT outputs away from the active edge.
    always @(negedge clk) begin
        int e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check({tag, "/R2 level"}, int'(level_o), e);
            check("R5 gate pattern", int'(gate_o), int'(8'h0F << e));
            check("R6 complement", int'(gate_o[3:0]), int'(~gate_o[7:4] & 4'hF));
        end
    end

    task automatic do_reset(input int b);
        @(negedge clk);
        rst = 1'b1; band_i = CNT_W'(b); tag = "R7";
        repeat (3) @(negedge clk);
        check("R7 reset level", int'(level_o), 2);
        check("R7 reset gate", int'(gate_o), 8'h3C);
        rst = 1'b0;
    endtask

    task automatic drive(input string t, input int r, input int cycles);
        @(negedge clk);
        tag = t; ref_i = REF_W'(r);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        do_reset(20);
        drive("R1", 0, 100);
        drive("R2", 15, 90);
        drive("R2", -27, 90);
        drive("R4", 1500, 100);     // above +2B: top level
        drive("R4", -1500, 100);    // below -2B: bottom level
        drive("R3", 40, 90);        // equals top peak
        drive("R3", -40, 90);       // equals bottom trough
        drive("R3", 20, 90);        // equals a band boundary
        for (int i = 0; i < 30; i++)
            drive("R8", (i * 37) % 81 - 40, 7);   // updates mid half-period
        do_reset(5);
        drive("R1", 3, 40);
        drive("R4", 11, 30);
        drive("R8", -6, 3);
        drive("R8", 9, 4);
        drive("R2", -4, 40);
        do_reset(1);
        drive("R1", 1, 20);
        drive("R3", 0, 20);
        done = 1'b1;
    end

    initial begin
        wait (done || cyc > 50000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule